// File: doc/BRIEF.md
# Image-Mode Integration Frame Counter

This block turns single-cycle hit pulses, one line per pixel, into image frames. Each pixel has its own live counter. The counters accumulate hits over an integration window measured in microsecond ticks. A prescaler of `TICK_DIV` clocks makes one tick, and a 16-bit window register sets the window to `win_len + 1` ticks. The longest window is therefore 65,536 ticks.

When a window closes, each live count is copied into a shadow bank. The copy includes any hit that arrives in the closing cycle. In the same cycle every live counter restarts from zero, so no hit is lost between frames. The shadow bank then streams out one pixel word per clock in index order. Each word is a full 16-bit count, or in the 8-bit image mode a count clamped to 255.

A once-per-second pulse realigns the window start without touching a readout in progress. A separate readout reset aborts only the streaming. Dropping the image-mode enable holds everything idle.

Top module: `im_frame_counter`

## Requirements
- R1: After enable, the first window closes on the clock edge ending cycle `(win_len+1)*TICK_DIV - 1`, counted from the first enabled cycle as cycle 0. Each later window spans `(win_len+1)*TICK_DIV` cycles. `out_valid` rises in the cycle after that edge.
- R2: With `mode8`=0, `out_data` carries the pixel's hit count over the window. The count saturates at 65535 instead of wrapping.
- R3: With `mode8`=1, the count saturates at 255. `out_data[7:0]` carries it and `out_data[15:8]` is zero.
- R4: A hit in the final cycle of a window is counted in the closing frame. A hit in the next cycle is counted in the following frame. No cycle is lost between windows.
- R5: An accepted frame is streamed as `NPIX` words on consecutive cycles with `out_valid`=1. `out_idx` runs from 0 to `NPIX-1`, and `out_last`=1 only on index `NPIX-1`.
- R6: If a window closes while `out_valid` is 1, that frame is dropped and `overrun` pulses high for one cycle. Counting restarts normally.
- R7: A `pps` cycle discards the partial window, including that cycle's hits, and the next cycle starts a new window. A readout already in progress continues unaffected.
- R8: `frame_rst` ends a readout in progress: `out_valid` is 0 from the next cycle. Window timing and live counts are unaffected.
- R9: While `im_en`=0, no counts accumulate, `out_valid` and `overrun` stay 0, and timing restarts at cycle 0 when enable returns.
- R10: After `rst_n` is low, `out_valid` and `overrun` read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| im_en | input | 1 | Image-mode enable; 0 holds the block idle |
| frame_rst | input | 1 | Readout-only reset |
| pps | input | 1 | Once-per-second realign pulse |
| mode8 | input | 1 | 1 selects 8-bit counts, 0 selects 16-bit |
| win_len | input | TW | Window length in ticks minus one |
| hit | input | NPIX | Per-pixel hit pulses |
| out_valid | output | 1 | Readout word valid |
| out_idx | output | $clog2(NPIX) | Pixel index of the current word |
| out_data | output | CW | Pixel count |
| out_last | output | 1 | Final word of the frame |
| overrun | output | 1 | One-cycle pulse when a frame is dropped |

## Verification
The properties assume that `win_len` and `mode8` change only while `im_en` is low or no readout is running. They also assume that `frame_rst` and `pps` never coincide with a window close. Under these assumptions the output index and clamping are well defined. The stimulus changes the window length and the mode only inside short disabled intervals. It places the `pps` and readout-reset pulses a few cycles into a readout, well clear of any window boundary.

// File: rtl/im_frame_counter.sv
module im_frame_counter #(
  parameter int NPIX     = 256,
  parameter int CW       = 16,
  parameter int TW       = 16,
  parameter int TICK_DIV = 100
)(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     im_en,
  input  logic                     frame_rst,
  input  logic                     pps,
  input  logic                     mode8,
  input  logic [TW-1:0]            win_len,
  input  logic [NPIX-1:0]          hit,
  output logic                     out_valid,
  output logic [$clog2(NPIX)-1:0]  out_idx,
  output logic [CW-1:0]            out_data,
  output logic                     out_last,
  output logic                     overrun
);
  localparam int IW = $clog2(NPIX);
  localparam int PW = $clog2(TICK_DIV);
  localparam logic [CW-1:0] LIM_W = '1;
  localparam logic [CW-1:0] LIM_B = CW'(255);

  logic [PW-1:0]      pre;
  logic [TW-1:0]      tcnt;
  logic               busy;
  logic [IW-1:0]      idx;
  logic [NPIX*CW-1:0] shflat;

  wire hold    = !rst_n || !im_en;
  wire tick    = pre == PW'(TICK_DIV - 1);
  wire win_end = !pps && tick && (tcnt == win_len);
  wire start   = win_end && !busy;
  wire [CW-1:0] lim = mode8 ? LIM_B : LIM_W;

  always_ff @(posedge clk) begin
    if (hold || pps) begin
      pre  <= '0;
      tcnt <= '0;
    end else if (tick) begin
      pre  <= '0;
      tcnt <= win_end ? '0 : tcnt + 1'b1;
    end else begin
      pre  <= pre + 1'b1;
    end
  end

  for (genvar g = 0; g < NPIX; g++) begin : g_pix
    logic [CW-1:0] live, shad;
    wire  [CW-1:0] nxt = live + CW'(hit[g] && (live < lim));
    always_ff @(posedge clk) begin
      if (hold || pps || win_end) live <= '0;
      else                        live <= nxt;
      if (start) shad <= nxt;
    end
    assign shflat[g*CW +: CW] = shad;
  end

  always_ff @(posedge clk) begin
    if (hold || frame_rst) begin
      busy <= 1'b0;
      idx  <= '0;
    end else if (start) begin
      busy <= 1'b1;
      idx  <= '0;
    end else if (busy) begin
      busy <= idx != IW'(NPIX - 1);
      idx  <= (idx == IW'(NPIX - 1)) ? '0 : idx + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (hold) overrun <= 1'b0;
    else      overrun <= win_end && busy;
  end

  wire [CW-1:0] sel = shflat[idx*CW +: CW];
  assign out_valid = busy;
  assign out_idx   = idx;
  assign out_last  = busy && (idx == IW'(NPIX - 1));
  assign out_data  = mode8 ? ((sel > LIM_B) ? LIM_B : sel) : sel;
endmodule

// File: rtl/im_frame_counter_chk.sv
module im_frame_counter_chk #(
  parameter int NPIX = 256,
  parameter int CW   = 16
)(
  input logic                    clk,
  input logic                    rst_n,
  input logic                    im_en,
  input logic                    frame_rst,
  input logic                    mode8,
  input logic                    out_valid,
  input logic [$clog2(NPIX)-1:0] out_idx,
  input logic [CW-1:0]           out_data,
  input logic                    out_last,
  input logic                    overrun
);
  // R5
  word_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_last && im_en && !frame_rst) |=> (out_valid && out_idx == $past(out_idx) + 1'b1));
  // R5
  last_index_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> (out_valid && out_idx == ($clog2(NPIX))'(NPIX - 1)));
  // R3
  byte_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode8 && out_valid) |-> (out_data[CW-1:8] == '0));
  // R6
  drop_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |-> $past(out_valid));
  // R9
  idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !im_en |=> (!out_valid && !overrun));
  // R8
  abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_rst |=> !out_valid);
endmodule

bind im_frame_counter im_frame_counter_chk #(.NPIX(NPIX), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .im_en(im_en), .frame_rst(frame_rst), .mode8(mode8),
  .out_valid(out_valid), .out_idx(out_idx), .out_data(out_data),
  .out_last(out_last), .overrun(overrun)
);

// File: tb/im_frame_counter_tb.sv
`timescale 1ns/1ps
module im_frame_counter_tb;
  localparam int NPIX = 8, CW = 16, TW = 16, DIV = 4;
  localparam int IW = $clog2(NPIX);

  logic clk = 0, rst_n = 0, im_en = 0, frame_rst = 0, pps = 0, mode8 = 0;
  logic [TW-1:0]   win_len = '0;
  logic [NPIX-1:0] hit = '0;
  logic            out_valid, out_last, overrun;
  logic [IW-1:0]   out_idx;
  logic [CW-1:0]   out_data;

  im_frame_counter #(.NPIX(NPIX), .CW(CW), .TW(TW), .TICK_DIV(DIV)) u_dut (
    .clk(clk), .rst_n(rst_n), .im_en(im_en), .frame_rst(frame_rst), .pps(pps),
    .mode8(mode8), .win_len(win_len), .hit(hit), .out_valid(out_valid),
    .out_idx(out_idx), .out_data(out_data), .out_last(out_last), .overrun(overrun));

  always #5 clk = ~clk;

  int tests = 0, fails = 0;
  int k = 0, rb = 0;
  int cnt [NPIX];
  bit exp_ovr = 0, mon_on = 0;
  string req = "R1";
  int q_data[$];
  int q_idx[$];

  task automatic chk(string r, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
    end
  endtask

  function automatic logic [NPIX-1:0] gen(int p, int kk);
    logic [NPIX-1:0] h = '0;
    for (int i = 0; i < NPIX; i++) begin
      case (p)
        1: h[i] = (kk % (i + 1)) == 0;
        2: h[i] = (i % 2 == 0) && (kk == 0 || kk == (int'(win_len) + 1) * DIV - 1);
        3: h[i] = (i == 0) || (kk % 4 == i % 4);
        4: h[i] = (i == 0);
        5: h[i] = 1'b1;
        default: h[i] = 1'b0;
      endcase
    end
    return h;
  endfunction

  task automatic clear_model();
    for (int i = 0; i < NPIX; i++) cnt[i] = 0;
  endtask

  // driver: one cycle of stimulus plus the expected effect of the next edge
  task automatic step(logic [NPIX-1:0] h, bit p, bit fr, bit en);
    int rbb, lim;
    @(negedge clk);
    hit = h; pps = p; frame_rst = fr; im_en = en;
    exp_ovr = 0;
    lim = mode8 ? 255 : 65535;
    if (!en) begin
      k = 0; rb = 0; clear_model(); q_data.delete(); q_idx.delete();
      return;
    end
    rbb = rb;
    if (rb > 0) rb--;
    if (fr) begin rb = 0; q_data.delete(); q_idx.delete(); end
    if (p) begin
      k = 0; clear_model();
    end else begin
      for (int i = 0; i < NPIX; i++) if (h[i] && cnt[i] < lim) cnt[i]++;
      if (k == (int'(win_len) + 1) * DIV - 1) begin
        k = 0;
        if (rbb > 0) exp_ovr = 1;
        else begin
          for (int i = 0; i < NPIX; i++) begin
            q_data.push_back(cnt[i]); q_idx.push_back(i);
          end
          rb = NPIX;
        end
        clear_model();
      end else k++;
    end
  endtask

  task automatic run(int n, int pat);
    for (int c = 0; c < n; c++) step(gen(pat, k), 0, 0, 1);
  endtask

  task automatic reconfig(int w, bit m8);
    step('1, 0, 0, 0);
    step('1, 0, 0, 0);
    win_len = TW'(w); mode8 = m8;
  endtask

  // monitor: scoreboard compare after each edge
  always @(posedge clk) begin
    #2;
    if (mon_on) begin
      chk({req, "/R5 valid"}, int'(out_valid), int'(rb > 0));
      chk({req, "/R6 overrun"}, int'(overrun), int'(exp_ovr));
      if (out_valid) begin
        if (q_data.size() == 0) chk({req, "/R5 unexpected word"}, 1, 0);
        else begin
          int ed, ei;
          ed = q_data.pop_front(); ei = q_idx.pop_front();
          chk({req, mode8 ? "/R3 data" : "/R2 data"}, int'(out_data), ed);
          chk({req, "/R5 index"}, int'(out_idx), ei);
          chk({req, "/R5 last"}, int'(out_last), int'(ei == NPIX - 1));
        end
      end
    end
  end

  initial begin
    #1_500_000;
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    clear_model();
    repeat (3) @(negedge clk);
    @(posedge clk); #2;
    chk("R10 valid after reset", int'(out_valid), 0);
    chk("R10 overrun after reset", int'(overrun), 0);
    @(negedge clk); rst_n = 1;
    mon_on = 1;

    req = "R9";  reconfig(2, 0);
    for (int c = 0; c < 6; c++) step('1, 0, 0, 0);
    req = "R1";  run(40, 1);
    req = "R4";  reconfig(3, 0); run(50, 2);
    req = "R3";  reconfig(99, 1); run(420, 3);
    req = "R2";  reconfig(16383, 0); run(65536 + 12, 4);
    req = "R6";  reconfig(0, 0); run(40, 1);
    req = "R7";  reconfig(3, 0); run(19, 1);
    step(gen(5, k), 1, 0, 1);
    run(45, 1);
    req = "R8";  reconfig(3, 0); run(19, 1);
    step(gen(1, k), 0, 1, 1);
    run(45, 1);
    req = "R9";  step('1, 0, 0, 0); run(12, 0);

    chk("R5 queue drained", q_data.size(), 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule